// File: doc/BRIEF.md
# PC Card Host Access Decoder

This block sits behind the host pins of a PC Card and turns host bus cycles into single-cycle read and write requests on an internal ATA-style register file. It takes the address, the 16-bit data bus, separate card enables for the even and the odd byte, the I/O and memory strobes and the register-select line. From these it works out which bytes of which register word are being accessed. It places the selected bytes on the correct data lanes in both directions, so that 8-bit and 16-bit hosts see the same register file.

When the card is configured as an I/O card, the block also drives the input-acknowledge line during I/O reads and the 16-bit-I/O indication for word accesses. It forwards an internal interrupt request to the host interrupt line. An idle timer asserts a sleep indication once the host has left every strobe inactive for a programmed number of clock cycles. Any host strobe clears that indication.

All host strobes and enables are active low. They are taken to be synchronous to `clk`. The register file answers reads combinationally through `reg_rdata`.

Top module: `pccard_host_decoder`

## Requirements
- R1: With both card enables low, the access is a full word: `reg_be` = 2'b11, `reg_wdata` equals `host_din`, and a read drives `reg_rdata` unchanged on both lanes (`host_doe` = 2'b11).
- R2: With only the even enable low and address bit 0 clear, only the even byte moves, on bits 7:0: `reg_be` = 2'b01, `reg_wdata[7:0]` = `host_din[7:0]`, and a read drives `reg_rdata[7:0]` on the low lane only (`host_doe` = 2'b01).
- R3: With only the even enable low and address bit 0 set, the odd byte travels on bits 7:0: `reg_be` = 2'b10, `reg_wdata[15:8]` = `host_din[7:0]`, and a read puts `reg_rdata[15:8]` on `host_dout[7:0]` with `host_doe` = 2'b01.
- R4: With only the odd enable low, the odd byte travels on bits 15:8: `reg_be` = 2'b10, `reg_wdata[15:8]` = `host_din[15:8]`, and a read drives `reg_rdata[15:8]` on the high lane only (`host_doe` = 2'b10).
- R5: A register access is decoded only for an I/O strobe with `reg_sel_n` low, or a memory strobe with `reg_sel_n` high, and with at least one enable low. Any other strobe (attribute-memory cycles, I/O strobes with `reg_sel_n` high, strobes with no enable) raises neither `reg_rd` nor `reg_wr` and drives no lane.
- R6: `reg_wr` and `reg_rd` are single-cycle pulses, high in the first cycle a decoded strobe is seen low, and `reg_addr` equals host address bits 10:1.
- R7: `host_doe` is nonzero only while a decoded read is in progress.
- R8: `inpack_n` is low exactly while the card is in I/O mode and a decoded I/O read is in progress. It stays high for memory reads.
- R9: `io16_n` is low exactly when the card is in I/O mode, `reg_sel_n` is low and both enables are low.
- R10: `irq_n` is low one cycle after `dev_irq` is high while the card is in I/O mode, and stays high whenever the card is not in I/O mode.
- R11: `sleep` rises after `idle_limit` consecutive clock edges with every host strobe inactive. An `idle_limit` of zero never sleeps.
- R12: Any host strobe held low across a clock edge clears `sleep` at that edge and restarts the idle count.
- R13: After reset, `sleep` is low, `irq_n` and `inpack_n` are high, no request pulse is raised and no lane is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Host address |
| host_din | input | 2*BYTE_W | Host write data |
| host_dout | output | 2*BYTE_W | Read data toward host |
| host_doe | output | 2 | Per-lane drive enable (bit 0 low lane, bit 1 high lane) |
| ce_even_n | input | 1 | Even-byte card enable |
| ce_odd_n | input | 1 | Odd-byte card enable |
| io_rd_n | input | 1 | I/O read strobe |
| io_wr_n | input | 1 | I/O write strobe |
| mem_oe_n | input | 1 | Memory output enable |
| mem_we_n | input | 1 | Memory write enable |
| reg_sel_n | input | 1 | Register select (low: I/O or attribute space) |
| io_card_mode | input | 1 | Card configured as I/O card |
| dev_irq | input | 1 | Interrupt request from the register logic |
| idle_limit | input | CNT_W | Idle cycles before sleep, 0 disables |
| inpack_n | output | 1 | Input acknowledge |
| io16_n | output | 1 | 16-bit I/O indication |
| irq_n | output | 1 | Host interrupt request |
| sleep | output | 1 | Auto-sleep indication |
| reg_addr | output | ADDR_W-1 | Register word address |
| reg_be | output | 2 | Byte enables (bit 0 even byte, bit 1 odd byte) |
| reg_wdata | output | 2*BYTE_W | Register write data |
| reg_rd | output | 1 | Read request pulse |
| reg_wr | output | 1 | Write request pulse |
| reg_rdata | input | 2*BYTE_W | Register read data |

## Verification
The assertions assume that the host never asserts a read strobe and a write strobe in the same cycle. They also assume that the strobes, enables and data change only between clock edges, and that `idle_limit` does not change while the timer is counting. The bench drives every input just after a falling edge and asserts one strobe at a time. It returns all strobes high between accesses and changes `idle_limit` only while a strobe is held low or the limit is irrelevant. Under these conditions, the pulse, lane and wake properties are checked against well-formed host cycles only.

// File: rtl/pchd_pkg.sv
// Shared types for the PC Card host access decoder.
// Assumes two byte lanes on the host data bus.
package pchd_pkg;
    localparam int LANES = 2;

    // Which byte(s) an access moves and on which lane.
    typedef enum logic [2:0] {
        LANE_NONE = 3'd0,  // no enable active
        LANE_WORD = 3'd1,  // both bytes, natural lanes
        LANE_EVEN = 3'd2,  // even byte on low lane
        LANE_SWAP = 3'd3,  // odd byte carried on low lane
        LANE_ODD  = 3'd4   // odd byte on high lane
    } lane_t;
endpackage

// File: rtl/pchd_lane_steer.sv
// Byte-lane steering: picks the lane mode from the two card enables and
// address bit 0, and maps write data, read data, byte enables and lane
// drive enables accordingly. Purely combinational; assumes the caller
// gates is_read with a decoded read.
module pchd_lane_steer
    import pchd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  ce_even_n,
    input  logic                  ce_odd_n,
    input  logic                  addr0,
    input  logic                  is_read,
    input  logic [2*BYTE_W-1:0]   din,
    input  logic [2*BYTE_W-1:0]   rdata,
    output lane_t                 mode,
    output logic [LANES-1:0]      be,
    output logic [2*BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0]   dout,
    output logic [LANES-1:0]      oe
);
    localparam int DW = 2 * BYTE_W;

    logic [LANES-1:0] lanes_used;

    // Classify the access from the enables and address bit 0.
    always_comb begin
        unique case ({ce_odd_n, ce_even_n})
            2'b00:   mode = LANE_WORD;
            2'b10:   mode = addr0 ? LANE_SWAP : LANE_EVEN;
            2'b01:   mode = LANE_ODD;
            default: mode = LANE_NONE;
        endcase
    end

    // Route bytes between host lanes and register bytes per mode.
    always_comb begin
        be         = '0;
        wdata      = '0;
        dout       = '0;
        lanes_used = '0;
        unique case (mode)
            LANE_WORD: begin
                be         = 2'b11;
                wdata      = din;
                dout       = rdata;
                lanes_used = 2'b11;
            end
            LANE_EVEN: begin
                be                 = 2'b01;
                wdata[BYTE_W-1:0]  = din[BYTE_W-1:0];
                dout[BYTE_W-1:0]   = rdata[BYTE_W-1:0];
                lanes_used         = 2'b01;
            end
            LANE_SWAP: begin
                be                 = 2'b10;
                wdata[DW-1:BYTE_W] = din[BYTE_W-1:0];
                dout[BYTE_W-1:0]   = rdata[DW-1:BYTE_W];
                lanes_used         = 2'b01;
            end
            LANE_ODD: begin
                be                 = 2'b10;
                wdata[DW-1:BYTE_W] = din[DW-1:BYTE_W];
                dout[DW-1:BYTE_W]  = rdata[DW-1:BYTE_W];
                lanes_used         = 2'b10;
            end
            default: ;
        endcase
    end

    // Drive lanes only for reads.
    always_comb oe = is_read ? lanes_used : '0;
endmodule

// File: rtl/pchd_strobe_decode.sv
// Strobe decode: qualifies host strobes with register select and the card
// enables, produces single-cycle read/write request pulses, and drives the
// input-acknowledge and 16-bit-I/O indications. Assumes strobes are
// synchronous to clk and read/write never overlap.
module pchd_strobe_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic io_rd_n,
    input  logic io_wr_n,
    input  logic mem_oe_n,
    input  logic mem_we_n,
    input  logic reg_sel_n,
    input  logic any_ce,
    input  logic both_ce,
    input  logic io_card_mode,
    output logic rd_act,
    output logic wr_act,
    output logic rd_pulse,
    output logic wr_pulse,
    output logic inpack_n,
    output logic io16_n,
    output logic host_busy
);
    logic rd_act_q, wr_act_q;
    logic io_read;

    // Decoded register cycles: I/O space or common memory space.
    always_comb begin
        io_read = any_ce && !io_rd_n && !reg_sel_n;
        rd_act  = io_read || (any_ce && !mem_oe_n && reg_sel_n);
        wr_act  = any_ce && ((!io_wr_n && !reg_sel_n) || (!mem_we_n && reg_sel_n));
    end

    // Remember last cycle's decode for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            wr_act_q <= 1'b0;
        end else begin
            rd_act_q <= rd_act;
            wr_act_q <= wr_act;
        end
    end

    // Request pulses in the first decoded cycle; host-facing indications.
    always_comb begin
        rd_pulse  = rd_act && !rd_act_q;
        wr_pulse  = wr_act && !wr_act_q;
        inpack_n  = !(io_card_mode && io_read);
        io16_n    = !(io_card_mode && both_ce && !reg_sel_n);
        host_busy = !io_rd_n || !io_wr_n || !mem_oe_n || !mem_we_n;
    end

    AST_INPACK_IO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !inpack_n |-> (io_card_mode && !io_rd_n && !reg_sel_n)); // R8
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse); // R6
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse); // R6
endmodule

// File: rtl/pchd_idle_timer.sv
// Host inactivity timer: counts clock edges with no host strobe and
// raises sleep after idle_limit of them; any strobe clears it and
// restarts the count. A limit of zero disables sleep. Assumes the
// limit is held stable while counting.
module pchd_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [CNT_W-1:0] limit,
    output logic             sleep
);
    logic [CNT_W-1:0] idle_cnt;

    // Count idle edges; wake and reload on any activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            sleep    <= 1'b0;
        end else if (busy) begin
            idle_cnt <= '0;
            sleep    <= 1'b0;
        end else if (!sleep && limit != '0) begin
            idle_cnt <= idle_cnt + CNT_W'(1);
            if (idle_cnt == limit - CNT_W'(1))
                sleep <= 1'b1;
        end
    end

    AST_WAKE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !sleep); // R12
    AST_SLEEP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> ($past(!busy) && $past(limit) != '0)); // R11
endmodule

// File: rtl/pccard_host_decoder.sv
// PC Card host access decoder top: combines strobe decode, byte-lane
// steering, interrupt forwarding and the auto-sleep timer. Assumes all
// host inputs are synchronous to clk and the register file returns
// read data combinationally on reg_rdata.
module pccard_host_decoder
    import pchd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [2*BYTE_W-1:0]   host_din,
    output logic [2*BYTE_W-1:0]   host_dout,
    output logic [1:0]            host_doe,
    input  logic                  ce_even_n,
    input  logic                  ce_odd_n,
    input  logic                  io_rd_n,
    input  logic                  io_wr_n,
    input  logic                  mem_oe_n,
    input  logic                  mem_we_n,
    input  logic                  reg_sel_n,
    input  logic                  io_card_mode,
    input  logic                  dev_irq,
    input  logic [CNT_W-1:0]      idle_limit,
    output logic                  inpack_n,
    output logic                  io16_n,
    output logic                  irq_n,
    output logic                  sleep,
    output logic [ADDR_W-2:0]     reg_addr,
    output logic [1:0]            reg_be,
    output logic [2*BYTE_W-1:0]   reg_wdata,
    output logic                  reg_rd,
    output logic                  reg_wr,
    input  logic [2*BYTE_W-1:0]   reg_rdata
);
    localparam int REG_AW = ADDR_W - 1;

    lane_t mode;
    logic  rd_act, wr_act, host_busy;
    logic  any_ce, both_ce;

    // Enable summaries for the strobe decoder.
    always_comb begin
        any_ce  = !ce_even_n || !ce_odd_n;
        both_ce = !ce_even_n && !ce_odd_n;
    end

    pchd_strobe_decode u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_rd_n      (io_rd_n),
        .io_wr_n      (io_wr_n),
        .mem_oe_n     (mem_oe_n),
        .mem_we_n     (mem_we_n),
        .reg_sel_n    (reg_sel_n),
        .any_ce       (any_ce),
        .both_ce      (both_ce),
        .io_card_mode (io_card_mode),
        .rd_act       (rd_act),
        .wr_act       (wr_act),
        .rd_pulse     (reg_rd),
        .wr_pulse     (reg_wr),
        .inpack_n     (inpack_n),
        .io16_n       (io16_n),
        .host_busy    (host_busy)
    );

    pchd_lane_steer #(.BYTE_W(BYTE_W)) u_lanes (
        .ce_even_n (ce_even_n),
        .ce_odd_n  (ce_odd_n),
        .addr0     (host_addr[0]),
        .is_read   (rd_act),
        .din       (host_din),
        .rdata     (reg_rdata),
        .mode      (mode),
        .be        (reg_be),
        .wdata     (reg_wdata),
        .dout      (host_dout),
        .oe        (host_doe)
    );

    pchd_idle_timer #(.CNT_W(CNT_W)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (host_busy),
        .limit (idle_limit),
        .sleep (sleep)
    );

    // Word address of the selected register.
    always_comb reg_addr = REG_AW'(host_addr[ADDR_W-1:1]);

    // Forward the interrupt only for an I/O-configured card.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= !(io_card_mode && dev_irq);
    end

    AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|host_doe) |-> (!io_rd_n || !mem_oe_n)); // R7
    AST_REQUEST_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> (|reg_be && mode != LANE_NONE)); // R5
    AST_IRQ_ONLY_IO_CARD: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(io_card_mode)); // R10
endmodule

// File: tb/tb_pccard_host_decoder.sv
// Directed bench for the PC Card host access decoder: one task per scenario.
module tb_pccard_host_decoder;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] RDATA = 16'hC35A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] host_addr = '0;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic [1:0]  host_doe;
    logic        ce_even_n = 1'b1, ce_odd_n = 1'b1;
    logic        io_rd_n = 1'b1, io_wr_n = 1'b1, mem_oe_n = 1'b1, mem_we_n = 1'b1;
    logic        reg_sel_n = 1'b1, io_card_mode = 1'b1, dev_irq = 1'b0;
    logic [15:0] idle_limit = '0;
    logic        inpack_n, io16_n, irq_n, sleep;
    logic [9:0]  reg_addr;
    logic [1:0]  reg_be;
    logic [15:0] reg_wdata;
    logic        reg_rd, reg_wr;
    logic [15:0] reg_rdata = RDATA;

    int n_checks = 0;
    int n_fail   = 0;

    pccard_host_decoder dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        @(negedge clk);
        {io_rd_n, io_wr_n, mem_oe_n, mem_we_n} = 4'b1111;
        {ce_even_n, ce_odd_n} = 2'b11;
        reg_sel_n = 1'b1;
    endtask

    // R13: state right after reset.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R13 sleep", 16'(sleep), 16'd0);
        check("R13 irq_n", 16'(irq_n), 16'd1);
        check("R13 inpack_n", 16'(inpack_n), 16'd1);
        check("R13 pulses", {14'd0, reg_rd, reg_wr}, 16'd0);
        check("R13 doe", 16'(host_doe), 16'd0);
    endtask

    // I/O write with given enables; checks be, masked wdata, address, pulse.
    task automatic t_io_write(input string req, input logic ce_e, input logic ce_o,
                              input logic [10:0] a, input logic [15:0] d,
                              input logic [1:0] exp_be, input logic [15:0] exp_wd);
        logic [15:0] mask;
        @(negedge clk);
        host_addr = a; host_din = d; ce_even_n = ce_e; ce_odd_n = ce_o;
        reg_sel_n = 1'b0; io_wr_n = 1'b0;
        #1;
        mask = {{8{exp_be[1]}}, {8{exp_be[0]}}};
        check({req, " be"}, 16'(reg_be), 16'(exp_be));
        check({req, " wdata"}, reg_wdata & mask, exp_wd);
        check("R6 wr pulse", 16'(reg_wr), 16'd1);
        check("R6 addr", 16'(reg_addr), 16'(a[10:1]));
        @(negedge clk); #1;
        check("R6 wr pulse ends", 16'(reg_wr), 16'd0);
        idle_bus();
    endtask

    // Read through I/O or memory space; checks lanes, data and acknowledge.
    task automatic t_read(input string req, input logic use_io, input logic ce_e, input logic ce_o,
                          input logic [10:0] a, input logic [1:0] exp_oe, input logic [15:0] exp_d);
        logic [15:0] mask;
        @(negedge clk);
        host_addr = a; ce_even_n = ce_e; ce_odd_n = ce_o;
        if (use_io) begin reg_sel_n = 1'b0; io_rd_n = 1'b0; end
        else        begin reg_sel_n = 1'b1; mem_oe_n = 1'b0; end
        #1;
        mask = {{8{exp_oe[1]}}, {8{exp_oe[0]}}};
        check({req, " doe"}, 16'(host_doe), 16'(exp_oe));
        check({req, " dout"}, host_dout & mask, exp_d);
        check("R6 rd pulse", 16'(reg_rd), 16'd1);
        check("R8 inpack_n", 16'(inpack_n), use_io ? 16'd0 : 16'd1);
        @(negedge clk); #1;
        check("R6 rd pulse ends", 16'(reg_rd), 16'd0);
        check("R7 doe held while reading", 16'(host_doe), 16'(exp_oe));
        idle_bus();
        #1;
        check("R7 doe after read", 16'(host_doe), 16'd0);
    endtask

    // R5: cycles that must not reach the register file.
    task automatic t_ignored();
        @(negedge clk);
        ce_even_n = 1'b0; reg_sel_n = 1'b0; mem_we_n = 1'b0; #1;
        check("R5 attribute write", {14'd0, reg_rd, reg_wr}, 16'd0);
        idle_bus();
        @(negedge clk);
        ce_even_n = 1'b0; reg_sel_n = 1'b0; mem_oe_n = 1'b0; #1;
        check("R5 attribute read doe", 16'(host_doe), 16'd0);
        check("R5 attribute read rd", 16'(reg_rd), 16'd0);
        idle_bus();
        @(negedge clk);
        reg_sel_n = 1'b0; io_rd_n = 1'b0; #1;
        check("R5 no enable doe", 16'(host_doe), 16'd0);
        check("R5 no enable inpack", 16'(inpack_n), 16'd1);
        idle_bus();
        @(negedge clk);
        ce_even_n = 1'b0; ce_odd_n = 1'b0; reg_sel_n = 1'b1; io_wr_n = 1'b0; #1;
        check("R5 io write without reg select", 16'(reg_wr), 16'd0);
        idle_bus();
    endtask

    // R9: 16-bit I/O indication.
    task automatic t_io16();
        @(negedge clk);
        ce_even_n = 1'b0; ce_odd_n = 1'b0; reg_sel_n = 1'b0; #1;
        check("R9 io16 word", 16'(io16_n), 16'd0);
        ce_odd_n = 1'b1; #1;
        check("R9 io16 byte", 16'(io16_n), 16'd1);
        ce_odd_n = 1'b0; io_card_mode = 1'b0; #1;
        check("R9 io16 memory card", 16'(io16_n), 16'd1);
        io_card_mode = 1'b1;
        idle_bus();
    endtask

    // R10: interrupt forwarding.
    task automatic t_irq();
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); #1;
        check("R10 irq asserted", 16'(irq_n), 16'd0);
        io_card_mode = 1'b0;
        @(negedge clk); #1;
        check("R10 irq gated", 16'(irq_n), 16'd1);
        io_card_mode = 1'b1; dev_irq = 1'b0;
        @(negedge clk); #1;
        check("R10 irq released", 16'(irq_n), 16'd1);
    endtask

    // R11/R12: sleep after the idle limit, wake on access.
    task automatic t_sleep();
        @(negedge clk); idle_limit = 16'd5; mem_oe_n = 1'b0;
        @(negedge clk); mem_oe_n = 1'b1;
        repeat (4) @(negedge clk);
        #1; check("R11 not yet asleep", 16'(sleep), 16'd0);
        @(negedge clk); #1;
        check("R11 asleep", 16'(sleep), 16'd1);
        io_wr_n = 1'b0;
        @(negedge clk); #1;
        check("R12 wake", 16'(sleep), 16'd0);
        idle_limit = 16'd0;
        io_wr_n = 1'b1;
        repeat (20) @(negedge clk);
        #1; check("R11 limit zero", 16'(sleep), 16'd0);
    endtask

    initial begin
        t_reset();
        t_io_write("R1 word write", 1'b0, 1'b0, 11'h2A6, 16'h1234, 2'b11, 16'h1234);
        t_io_write("R2 even write", 1'b0, 1'b1, 11'h2A6, 16'hAB56, 2'b01, 16'h0056);
        t_io_write("R3 swapped write", 1'b0, 1'b1, 11'h2A7, 16'hAB77, 2'b10, 16'h7700);
        t_io_write("R4 odd write", 1'b1, 1'b0, 11'h2A7, 16'h99CC, 2'b10, 16'h9900);
        t_read("R1 word read", 1'b1, 1'b0, 1'b0, 11'h010, 2'b11, RDATA);
        t_read("R1 memory word read", 1'b0, 1'b0, 1'b0, 11'h010, 2'b11, RDATA);
        t_read("R2 even read", 1'b1, 1'b0, 1'b1, 11'h010, 2'b01, 16'h005A);
        t_read("R3 swapped read", 1'b1, 1'b0, 1'b1, 11'h011, 2'b01, 16'h00C3);
        t_read("R4 odd read", 1'b1, 1'b1, 1'b0, 11'h011, 2'b10, 16'hC300);
        t_ignored();
        t_io16();
        t_irq();
        t_sleep();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule